// File: doc/BRIEF.md
# Noise-Shaped Duty Word Truncator

This block sits between a digital control law and a coarse counter-based pulse-width stage. Once per switching period it receives a wide duty command and emits a narrower duty word. The low-order fraction bits that the pulse stage cannot resolve are not thrown away. They are fed through two cascaded first-order error-feedback accumulators. The carries from these accumulators dither the narrow word up and down by a least significant bit, so that its mean over many periods tracks the wide command.

The first accumulator adds the fraction bits to its stored remainder. Its carry becomes the first correction bit, and its new remainder drives the second accumulator. The second accumulator's carry enters the correction once directly and once negated one period later. This gives second-order shaping of the truncation noise. The resulting correction ranges from -1 to +2. It is added to the integer part of the command and clamped to the representable range. The modulator state moves only when a period strobe is present. The registered output is flagged valid for one cycle after each strobe.

Top module: `mash_duty_trunc`

## Requirements
- R1: Synchronous reset clears both accumulator remainders, the delayed second-stage carry, the output word and the valid flag. With the default widths, the first strobe after reset therefore outputs exactly the upper 6 bits of the command (command bits 10..6... that is, bits 10 down to 5).
- R2: `valid_o` is high in exactly the cycle after a cycle with `stb_i` high, and low otherwise.
- R3: Without a strobe, the accumulator remainders, the delayed carry and `duty_o` keep their values. Idle cycles inserted between strobes leave the output sequence unchanged.
- R4: The first stage adds command bits 4..0 to its 5-bit remainder. The carry out of that addition is c1, and the low 5 bits become the new remainder.
- R5: The second stage adds the new first-stage remainder to its own 5-bit remainder, giving carry c2. The output is bits 10..5 of the command plus c1 + c2 − c2_prev, where c2_prev is c2 from the previous strobe.
- R6: The sum is clamped to the range 0 to 63. It never wraps around.
- R7: For any constant command whose upper 6 bits lie between 1 and 61, the sum of 32 consecutive output words differs from the 11-bit command by at most 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stb_i | input | 1 | Period strobe; advances the modulator one step |
| duty_i | input | 11 | Wide duty command, sampled on a strobe |
| duty_o | output | 6 | Truncated, noise-shaped duty word |
| valid_o | output | 1 | High for one cycle after each strobe |

## Verification
Two things can land on the same output word: the three-term carry correction and the range clamp. This happens when the integer part of the command already sits at 63 while c1 or c2 adds, or sits at 0 while the delayed carry subtracts. The bench provokes both cases by holding the command at 2047 and at small values, and by sweeping every command for 32 periods. Each word is compared with an arithmetic model of the carry rules that also applies the clamp. For commands away from the rails, each 32-period sum is compared with the wide command.

// File: rtl/mash_pkg.sv
`timescale 1ns/1ps
package mash_pkg;
   localparam int DEF_IN_W  = 11;
   localparam int DEF_OUT_W = 6;
   // correction c1 + c2 - c2_prev spans -1..+2, fits a 3-bit signed value
   typedef logic signed [2:0] corr_t;
endpackage

// File: rtl/mash_acc_stage.sv
`timescale 1ns/1ps
module mash_acc_stage #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         adv,
   input  logic [W-1:0] in_i,
   output logic         carry_o,
   output logic [W-1:0] resid_o
);
   logic [W:0]   sum;
   logic [W-1:0] rem_q;

   assign sum     = {1'b0, rem_q} + {1'b0, in_i};
   assign carry_o = sum[W];
   assign resid_o = sum[W-1:0];

   always_ff @(posedge clk) begin
      if (rst)
         rem_q <= '0;
      else if (adv)
         rem_q <= resid_o;
   end

   // remainder frozen between strobes
   p_rem_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(rem_q));
   // a carry means the remainder wrapped below its old value
   p_carry_wrap_r4: assert property (@(posedge clk) disable iff (rst)
      (adv && carry_o) |=> (rem_q < $past(rem_q)));
   p_nocarry_grow_r4: assert property (@(posedge clk) disable iff (rst)
      (adv && !carry_o) |=> (rem_q >= $past(rem_q)));
endmodule

// File: rtl/mash_recombine.sv
`timescale 1ns/1ps
module mash_recombine
   import mash_pkg::*;
#(
   parameter int OUT_W = 6
) (
   input  logic [OUT_W-1:0] msb_i,
   input  logic             c1_i,
   input  logic             c2_i,
   input  logic             c2_prev_i,
   output logic [OUT_W-1:0] word_o
);
   localparam int SW = OUT_W + 2;
   localparam logic signed [SW-1:0] TOP = SW'((1 << OUT_W) - 1);

   corr_t               corr;
   logic signed [SW-1:0] wide;

   always_comb begin
      corr = corr_t'({2'b00, c1_i}) + corr_t'({2'b00, c2_i})
           - corr_t'({2'b00, c2_prev_i});
      wide = $signed({2'b00, msb_i}) + {{(SW-3){corr[2]}}, corr};
      if (wide < 0)
         word_o = '0;
      else if (wide > TOP)
         word_o = TOP[OUT_W-1:0];
      else
         word_o = wide[OUT_W-1:0];
   end
endmodule

// File: rtl/mash_duty_trunc.sv
`timescale 1ns/1ps
module mash_duty_trunc
   import mash_pkg::*;
#(
   parameter int IN_W  = DEF_IN_W,
   parameter int OUT_W = DEF_OUT_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             stb_i,
   input  logic [IN_W-1:0]  duty_i,
   output logic [OUT_W-1:0] duty_o,
   output logic             valid_o
);
   localparam int FRAC_W = IN_W - OUT_W;
   localparam int NSTAGE = 2;
   localparam logic [OUT_W-1:0] WMAX = '1;

   if (FRAC_W < 1) begin : g_bad_width
      $error("mash_duty_trunc: IN_W must exceed OUT_W");
   end
   if (OUT_W < 2) begin : g_bad_out
      $error("mash_duty_trunc: OUT_W must be at least 2");
   end
   if (FRAC_W > 16) begin : g_bad_frac
      $error("mash_duty_trunc: more than 16 fraction bits not supported");
   end

   logic [NSTAGE-1:0][FRAC_W-1:0] st_in;
   logic [NSTAGE-1:0][FRAC_W-1:0] st_res;
   logic [NSTAGE-1:0]             st_c;
   logic                          c2_q;
   logic [OUT_W-1:0]              word;
   logic [OUT_W-1:0]              msb;

   assign msb = duty_i[IN_W-1:FRAC_W];

   for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
      if (g == 0) begin : g_head
         assign st_in[g] = duty_i[FRAC_W-1:0];
      end else begin : g_chain
         assign st_in[g] = st_res[g-1];
      end
      mash_acc_stage #(.W(FRAC_W)) u_acc (
         .clk     (clk),
         .rst     (rst),
         .adv     (stb_i),
         .in_i    (st_in[g]),
         .carry_o (st_c[g]),
         .resid_o (st_res[g])
      );
   end

   mash_recombine #(.OUT_W(OUT_W)) u_mix (
      .msb_i     (msb),
      .c1_i      (st_c[0]),
      .c2_i      (st_c[NSTAGE-1]),
      .c2_prev_i (c2_q),
      .word_o    (word)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         c2_q    <= 1'b0;
         duty_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= stb_i;
         if (stb_i) begin
            c2_q   <= st_c[NSTAGE-1];
            duty_o <= word;
         end
      end
   end

   p_valid_after_stb_r2: assert property (@(posedge clk) disable iff (rst)
      stb_i |=> valid_o);
   p_valid_quiet_r2: assert property (@(posedge clk) disable iff (rst)
      !stb_i |=> !valid_o);
   p_out_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !stb_i |=> $stable(duty_o));
   p_prev_carry_r5: assert property (@(posedge clk) disable iff (rst)
      stb_i |=> (c2_q == $past(st_c[NSTAGE-1])));
   p_tail_wrap_r5: assert property (@(posedge clk) disable iff (rst)
      (stb_i && st_c[NSTAGE-1]) |-> (st_res[NSTAGE-1] < st_in[NSTAGE-1]));
   p_clip_high_r6: assert property (@(posedge clk) disable iff (rst)
      (stb_i && msb == WMAX && st_c[0]) |=> (duty_o == WMAX));
   p_clip_low_r6: assert property (@(posedge clk) disable iff (rst)
      (stb_i && msb == '0 && !st_c[0] && !st_c[NSTAGE-1] && c2_q) |=> (duty_o == '0));
endmodule

// File: tb/sim_mash_duty_trunc.sv
`timescale 1ns/1ps
module sim_mash_duty_trunc;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        stb = 1'b0;
   logic [10:0] duty = '0;
   logic [5:0]  duty_o;
   logic        valid_o;

   int n_cmp = 0;
   int n_bad = 0;
   int me1 = 0, me2 = 0, mcd = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   mash_duty_trunc u0 (
      .clk(clk), .rst(rst), .stb_i(stb), .duty_i(duty),
      .duty_o(duty_o), .valid_o(valid_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // arithmetic model of the carry rules (R4, R5, R6)
   function automatic int model_step(input int d);
      int f, m, s1, s2, c1, c2, v;
      f  = d % 32;
      m  = d / 32;
      s1 = me1 + f;  c1 = s1 / 32;  me1 = s1 % 32;
      s2 = me2 + me1; c2 = s2 / 32; me2 = s2 % 32;
      v  = m + c1 + c2 - mcd;
      mcd = c2;
      if (v < 0) v = 0;
      if (v > 63) v = 63;
      return v;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; stb = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      me1 = 0; me2 = 0; mcd = 0;
   endtask

   task automatic step(input int d, output int got, output bit v);
      @(negedge clk);
      stb  = 1'b1;
      duty = d[10:0];
      @(negedge clk);
      got = int'(duty_o);
      v   = valid_o;
      stb = 1'b0;
   endtask

   task automatic step_cmp(input int d, input string req, output int got);
      int exp;
      bit v;
      exp = model_step(d);
      step(d, got, v);
      chk(v == 1'b1, "R2", int'(v), 1);
      chk(got == exp, req, got, exp);
   endtask

   initial begin
      #(10ns * 190000);
      if (!done) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int got, lfsr, sum, d;
      bit v;
      do_reset();
      @(negedge clk);
      chk(valid_o == 1'b0, "R1", int'(valid_o), 0);
      chk(duty_o == 6'd0, "R1", int'(duty_o), 0);

      // R1: first strobe after reset gives the integer part exactly
      me1 = 0; me2 = 0; mcd = 0;
      void'(model_step(11'h3FF));
      step(11'h3FF, got, v);
      chk(got == 31, "R1", got, 31);
      chk(v == 1'b1, "R2", int'(v), 1);

      // R2/R3: idle cycles hold the word and drop valid
      repeat (4) begin
         @(negedge clk);
         chk(valid_o == 1'b0, "R2", int'(valid_o), 0);
         chk(duty_o == 6'd31, "R3", int'(duty_o), 31);
      end

      // R3/R4/R5: pseudo-random commands with uneven idle gaps
      do_reset();
      lfsr = 16'hACE1;
      for (int i = 0; i < 300; i++) begin
         lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
         step_cmp(lfsr % 2048, "R5", got);
         repeat (lfsr % 4) @(negedge clk);
      end

      // R6: upper rail, correction would push beyond 63
      do_reset();
      for (int i = 0; i < 70; i++) begin
         step_cmp(2047, "R6", got);
         chk(got >= 62, "R6", got, 62);
      end
      // R6: lower rail, delayed carry would push below 0
      do_reset();
      for (int i = 0; i < 70; i++) begin
         step_cmp(1 + (i % 3) * 9, "R6", got);
         chk(got <= 2, "R6", got, 2);
      end

      // R4: only fraction bits -> carries at the expected rate from reset
      do_reset();
      sum = 0;
      for (int i = 0; i < 32; i++) begin
         step_cmp(11'd16 + 11'd64, "R4", got);
         sum += got;
      end
      chk(sum == 80, "R4", sum, 80);

      // R7: every command held for 32 periods
      do_reset();
      for (int k = 0; k < 2048; k++) begin
         sum = 0;
         for (int i = 0; i < 32; i++) begin
            step_cmp(k, "R5", got);
            sum += got;
         end
         d = sum - k;
         if ((k / 32) >= 1 && (k / 32) <= 61)
            chk(d <= 2 && d >= -2, "R7", sum, k);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule